// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This block sits between a processor core and a word-wide data memory. It serves word and byte accesses. The core gives a base register value and a 16-bit signed displacement, and the block adds them to form a byte address. A store request produces a registered word address, a per-lane write-enable mask and lane-positioned write data, so a byte store changes one byte of the memory word and leaves the other bytes as they were. A load request issues a read. The memory answers one cycle later. The unit then selects the addressed byte lane, moves it to the low bits of the result and extends it with sign or zeros, as the request asks.

A static `big_endian` input sets how byte offsets inside a word map onto bit lanes. A word access whose address is not a multiple of the word size is not sent to memory. It raises a one-cycle fault flag instead. Byte accesses are never misaligned.

Top module: `lsu_top`

## Requirements
- R1: The byte address is `base_val` plus `offset_imm` sign-extended to ADDR_W bits, wrapping modulo 2^ADDR_W. `mem_addr` is that address with its two low bits dropped, valid in the cycle after the request is sampled.
- R2: A word store drives `mem_en`=1, `mem_we`=1, `mem_be`=4'b1111 and `mem_wdata`=`store_val` in the cycle after the request.
- R3: A byte store drives exactly one `mem_be` bit. With `big_endian`=1, byte offset k (address bits 1:0) selects lane 3-k. With `big_endian`=0 it selects lane k. Lane j is `mem_be[j]` and data bits 8j+7:8j. The byte `store_val[7:0]` appears in every lane of `mem_wdata`.
- R4: `mem_be` is all zero in every cycle in which `mem_we` is low.
- R5: For a word load sampled at edge k, `load_valid` is high after edge k+2 and `load_data` equals the word the memory returned.
- R6: A byte load returns, in bits 7:0, the byte in the lane chosen by the R3 mapping. Example: word 0x009012A0 at byte address 1 gives 0x90 in big-endian mode and 0x12 in little-endian mode.
- R7: When `req_signed`=1, a byte load copies bit 7 into bits 31:8. When it is 0, bits 31:8 are zero.
- R8: A word access with address bits 1:0 not zero sets `misalign` for one cycle, with `mem_en` and `mem_we` low and no `load_valid`. Memory is not changed.
- R9: While reset is held, and in the cycle after it, every output is zero.
- R10: A byte store leaves the other three bytes of the word unchanged. Example: storing 0x90 at address 6 into the all-ones word at address 4 gives 0xFFFF90FF in big-endian mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | Byte numbering: 1 means offset 0 is the most significant byte |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_signed | input | 1 | Byte load: 1 sign-extends, 0 zero-extends |
| base_val | input | 32 | Base register value |
| offset_imm | input | 16 | Signed displacement |
| store_val | input | 32 | Store source register value |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-positioned write data |
| misalign | output | 1 | Misaligned word access rejected |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extended load result |

## Verification
The bench builds the unit with its default parameters: a 32-bit data word (four lanes), a 32-bit address and a 16-bit displacement. This means the displacement is sign-extended over 16 upper bits, negative displacements can wrap the base below zero, and every lane and offset combination can be reached under both endianness settings. A 16-word memory model in the bench, together with a shadow copy, lets byte stores be read back as whole words. This exposes any damage to neighbouring bytes.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef struct packed {
    logic is_byte;
    logic sext;
  } ld_fmt_t;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 16,
  parameter int LANE_BITS = 2
) (
  input  logic [ADDR_W-1:0]           base_in,
  input  logic [OFF_W-1:0]            off_in,
  input  logic                        is_byte,
  output logic [ADDR_W-LANE_BITS-1:0] word_addr,
  output logic [LANE_BITS-1:0]        byte_off,
  output logic                        unaligned
);
  localparam int EXT_W = ADDR_W - OFF_W;
  logic [ADDR_W-1:0] ea;

  always_comb begin
    ea        = base_in + {{EXT_W{off_in[OFF_W-1]}}, off_in};
    word_addr = ea[ADDR_W-1:LANE_BITS];
    byte_off  = ea[LANE_BITS-1:0];
    unaligned = !is_byte && (byte_off != '0);
  end
endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map #(
  parameter int LANE_BITS = 2
) (
  input  logic                 big,
  input  logic [LANE_BITS-1:0] off,
  output logic [LANE_BITS-1:0] lane
);
  // Lane count is a power of two, so (LANES-1-off) equals ~off.
  always_comb lane = big ? ~off : off;
endmodule

// File: rtl/lsu_store_fmt.sv
module lsu_store_fmt #(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  input  logic                        is_byte,
  input  logic [DATA_W-1:0]           src,
  output logic [DATA_W/8-1:0]         be,
  output logic [DATA_W-1:0]           wdata
);
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g]          = is_byte ? (lane == LANE_BITS'(g)) : 1'b1;
    assign wdata[g*8 +: 8] = is_byte ? src[7:0] : src[g*8 +: 8];
  end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]           word,
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  input  lsu_pkg::ld_fmt_t            fmt,
  output logic [DATA_W-1:0]           result
);
  localparam int LANES = DATA_W / 8;
  logic [7:0] lane_bytes [LANES];
  logic [7:0] sel;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lane_bytes[g] = word[g*8 +: 8];
  end

  always_comb begin
    sel = lane_bytes[lane];
    if (fmt.is_byte)
      result = {{(DATA_W-8){fmt.sext & sel[7]}}, sel};
    else
      result = word;
  end
endmodule

// File: rtl/lsu_top.sv
module lsu_top #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                big_endian,
  input  logic                                req_valid,
  input  logic                                req_write,
  input  logic                                req_byte,
  input  logic                                req_signed,
  input  logic [ADDR_W-1:0]                   base_val,
  input  logic [OFF_W-1:0]                    offset_imm,
  input  logic [DATA_W-1:0]                   store_val,
  input  logic [DATA_W-1:0]                   mem_rdata,
  output logic                                mem_en,
  output logic                                mem_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]  mem_addr,
  output logic [DATA_W/8-1:0]                 mem_be,
  output logic [DATA_W-1:0]                   mem_wdata,
  output logic                                misalign,
  output logic                                load_valid,
  output logic [DATA_W-1:0]                   load_data
);
  import lsu_pkg::*;

  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);
  localparam int WADDR_W   = ADDR_W - LANE_BITS;

  logic [WADDR_W-1:0]   c_waddr;
  logic [LANE_BITS-1:0] c_off, c_lane;
  logic                 c_unal;
  logic [LANES-1:0]     c_be;
  logic [DATA_W-1:0]    c_wdata;
  logic                 c_ok, c_wr, c_rd;

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_BITS(LANE_BITS)) i_agen (
    .base_in(base_val), .off_in(offset_imm), .is_byte(req_byte),
    .word_addr(c_waddr), .byte_off(c_off), .unaligned(c_unal)
  );

  lsu_lane_map #(.LANE_BITS(LANE_BITS)) i_map (
    .big(big_endian), .off(c_off), .lane(c_lane)
  );

  lsu_store_fmt #(.DATA_W(DATA_W)) i_sfmt (
    .lane(c_lane), .is_byte(req_byte), .src(store_val),
    .be(c_be), .wdata(c_wdata)
  );

  always_comb begin
    c_ok = req_valid && !c_unal;
    c_wr = c_ok && req_write;
    c_rd = c_ok && !req_write;
  end

  // Load side pipeline: request stage, memory-return stage.
  logic                 rd_s1, rd_s2;
  logic [LANE_BITS-1:0] lane_s1, lane_s2;
  ld_fmt_t              fmt_s1, fmt_s2;
  logic [DATA_W-1:0]    ld_c;

  lsu_load_fmt #(.DATA_W(DATA_W)) i_lfmt (
    .word(mem_rdata), .lane(lane_s2), .fmt(fmt_s2), .result(ld_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en     <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
      misalign   <= 1'b0;
      rd_s1      <= 1'b0;
      rd_s2      <= 1'b0;
      lane_s1    <= '0;
      lane_s2    <= '0;
      fmt_s1     <= '0;
      fmt_s2     <= '0;
      load_valid <= 1'b0;
      load_data  <= '0;
    end else begin
      mem_en    <= c_ok;
      mem_we    <= c_wr;
      misalign  <= req_valid && c_unal;
      if (c_ok) mem_addr <= c_waddr;
      mem_be    <= c_wr ? c_be : '0;
      if (c_wr) mem_wdata <= c_wdata;

      rd_s1 <= c_rd;
      if (c_rd) begin
        lane_s1 <= c_lane;
        fmt_s1  <= '{is_byte: req_byte, sext: req_signed};
      end
      rd_s2   <= rd_s1;
      lane_s2 <= lane_s1;
      fmt_s2  <= fmt_s1;

      load_valid <= rd_s2;
      if (rd_s2) load_data <= ld_c;
    end
  end
endmodule

// File: rtl/lsu_top_chk.sv
module lsu_top_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                mem_en,
  input logic                mem_we,
  input logic [DATA_W/8-1:0] mem_be,
  input logic                misalign,
  input logic                load_valid
);
  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (!mem_en && !mem_we)); // R8
  AST_WRITE_HAS_STROBE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en); // R2
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($countones(mem_be) == 1 || mem_be == '1)); // R3
  AST_BE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !mem_we |-> (mem_be == '0)); // R4
  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    load_valid |-> $past(mem_en && !mem_we, 2)); // R5
endmodule

bind lsu_top lsu_top_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .mem_en(mem_en), .mem_we(mem_we),
  .mem_be(mem_be), .misalign(misalign), .load_valid(load_valid)
);

// File: tb/test_lsu_top.sv
`timescale 1ns/1ps
module test_lsu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        big_endian = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0, req_signed = 1'b0;
  logic [31:0] base_val = '0;
  logic [15:0] offset_imm = '0;
  logic [31:0] store_val = '0;
  logic [31:0] mem_rdata;
  logic        mem_en, mem_we, misalign, load_valid;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, load_data;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  lsu_top i_lsu_top (
    .clk(clk), .rst(rst), .big_endian(big_endian), .req_valid(req_valid),
    .req_write(req_write), .req_byte(req_byte), .req_signed(req_signed),
    .base_val(base_val), .offset_imm(offset_imm), .store_val(store_val),
    .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .misalign(misalign), .load_valid(load_valid), .load_data(load_data)
  );

  // Memory model: 16 words, read data one cycle after request.
  logic [31:0] ram [16];
  logic [31:0] shadow [16];
  initial mem_rdata = '0;
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int j = 0; j < 4; j++)
          if (mem_be[j]) ram[mem_addr[3:0]][j*8 +: 8] <= mem_wdata[j*8 +: 8];
      end else begin
        mem_rdata <= ram[mem_addr[3:0]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] lane_of(input bit big, input logic [1:0] off);
    return big ? 2'(3 - off) : off;
  endfunction

  function automatic logic [31:0] exp_load(input logic [31:0] w, input bit bt,
                                           input bit sg, input logic [1:0] ln);
    logic [7:0] b;
    b = w[ln*8 +: 8];
    if (!bt) return w;
    return sg ? {{24{b[7]}}, b} : {24'h0, b};
  endfunction

  task automatic access(input bit wr, input bit bt, input bit sg,
                        input logic [31:0] base, input logic [15:0] off,
                        input logic [31:0] sval, input string tag);
    logic [31:0] ea, exp_wd;
    logic [3:0]  exp_be;
    logic [1:0]  ln;
    bit          mis;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_byte = bt; req_signed = sg;
    base_val = base; offset_imm = off; store_val = sval;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ea  = base + {{16{off[15]}}, off};
    mis = !bt && (ea[1:0] != 2'b00);
    ln  = lane_of(big_endian, ea[1:0]);
    chk(misalign == mis, "R8 misalign flag", 32'(misalign), 32'(mis));
    chk(mem_en == !mis, "R8 strobe", 32'(mem_en), 32'(!mis));
    chk(mem_we == (wr && !mis), "R2 write strobe", 32'(mem_we), 32'(wr && !mis));
    if (!mis) chk(mem_addr == ea[31:2], "R1 word address", 32'(mem_addr), 32'(ea[31:2]));
    if (!mem_we) chk(mem_be == 4'h0, "R4 idle enables", 32'(mem_be), 32'h0);
    if (wr && !mis) begin
      if (bt) begin
        exp_be = 4'b0001 << ln;
        exp_wd = {4{sval[7:0]}};
        shadow[ea[5:2]][ln*8 +: 8] = sval[7:0];
        chk(mem_be == exp_be, "R3 byte lane enable", 32'(mem_be), 32'(exp_be));
        chk(mem_wdata == exp_wd, "R3 byte write data", mem_wdata, exp_wd);
      end else begin
        shadow[ea[5:2]] = sval;
        chk(mem_be == 4'hF, "R2 word enables", 32'(mem_be), 32'hF);
        chk(mem_wdata == sval, "R2 word write data", mem_wdata, sval);
      end
    end
    if (!wr) begin
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk(load_valid == !mis, {tag, " R5 load valid"}, 32'(load_valid), 32'(!mis));
      if (!mis)
        chk(load_data == exp_load(shadow[ea[5:2]], bt, sg, ln),
            bt ? {tag, " R6 R7 byte load"} : {tag, " R5 word load"},
            load_data, exp_load(shadow[ea[5:2]], bt, sg, ln));
    end
  endtask

  initial begin
    #(8ns * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({mem_en, mem_we, misalign, load_valid} == 4'h0 && mem_be == 0 &&
        mem_addr == 0 && mem_wdata == 0 && load_data == 0,
        "R9 reset outputs", {mem_en, mem_we, misalign, load_valid}, 32'h0);
    rst = 1'b0;

    // Fill all 16 words with word stores (R2).
    for (int i = 0; i < 16; i++)
      access(1, 0, 0, 32'(i * 4), 16'h0, $urandom, "init");

    // Directed corner cases, big-endian.
    big_endian = 1'b1;
    access(1, 0, 0, 32'h0, 16'h0000, 32'h009012A0, "R2");
    access(1, 0, 0, 32'h0, 16'h0004, 32'hFFFFFFFF, "R2");
    access(0, 1, 1, 32'h0, 16'h0001, 0, "R6 big signed");    // 0xFFFFFF90
    access(0, 1, 0, 32'h0, 16'h0001, 0, "R7 big unsigned");  // 0x00000090
    access(1, 1, 0, 32'h10, 16'hFFF6, 32'h00000090, "R1");   // address 6
    access(0, 0, 0, 32'h0, 16'h0004, 0, "R10 word readback"); // 0xFFFF90FF
    chk(shadow[1] == 32'hFFFF90FF, "R10 model", shadow[1], 32'hFFFF90FF);
    big_endian = 1'b0;
    access(0, 1, 0, 32'h0, 16'h0001, 0, "R6 little");        // 0x00000012
    access(0, 1, 1, 32'h0, 16'h0003, 0, "R7 little zero top"); // 0x00000000
    // Misaligned word accesses (R8).
    access(0, 0, 0, 32'h0, 16'h0002, 0, "R8 load");
    access(1, 0, 0, 32'h5, 16'h0000, 32'h12345678, "R8 store");
    access(0, 0, 0, 32'h4, 16'h0000, 0, "R8 memory unchanged");
    // Wrap below zero (R1).
    access(0, 0, 0, 32'h00000004, 16'h8000, 0, "R1 wrap");

    // Constrained random mix.
    for (int i = 0; i < 400; i++) begin
      logic [31:0] tgt, b;
      logic [15:0] o;
      big_endian = 1'($urandom);
      tgt = 32'($urandom_range(0, 63));
      o   = 16'($urandom);
      b   = tgt - {{16{o[15]}}, o};
      access(1'($urandom), 1'($urandom), 1'($urandom), b, o, $urandom, "rand");
    end

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule